// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Character Error Tags

This block receives asynchronous serial characters from a single line. The line is sampled against a pulse that arrives sixteen times per bit period, and that pulse comes from a divisor generator outside the block. Each character is assembled least significant bit first. The character length, the parity mode and the enables come from line-control inputs. These settings are latched when a start bit is confirmed, so a change made mid-frame does not disturb the character in flight.

Every finished character becomes one 12-bit word on a write port that feeds a receive FIFO, which lives outside the block. The upper four bits of the word tag that character with its own framing, parity, break and overrun status. Software can therefore attribute each error to the exact byte that carried it.

When the FIFO reports full, the character is dropped and a pulse marks the loss. The next word that does get written carries the overrun tag.

Top module: `rx_char_tagger`

## Requirements
- R1: A written word places the character in bits 7:0, with unused upper data bits zero. Bit 8 is framing error, bit 9 parity error, bit 10 break and bit 11 overrun. Exactly one single-cycle `push_o` pulse is produced per accepted character.
- R2: `wlen_i` selects the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8.
- R3: With `par_en_i` high and `par_stick_i` low, a parity bit follows the data. Even parity applies when `par_even_i` is 1 and odd parity when it is 0, and a mismatch sets bit 9.
- R4: With `par_stick_i` and `par_en_i` both high, the parity bit is expected to be 0 when `par_even_i` is 1 and 1 when `par_even_i` is 0. With `par_en_i` low, no parity bit is received and bit 9 stays 0.
- R5: A falling edge is confirmed as a start bit only if the line is still low at the 8th tick after it. A pulse that is high again by then produces no word and leaves `busy_o` low.
- R6: A first stop bit sampled low sets bit 8 and keeps the received data. The receiver then waits for the line to go high before it looks for a new start bit.
- R7: A line held low through start, data, parity (if enabled) and stop writes exactly one word of value 0x500: data 0, break and framing set, parity clear. Nothing more is written until the line has returned high.
- R8: A character that completes while `fifo_full_i` is high is not written, and `overrun_o` pulses for one cycle. The next word written has bit 11 set, and the word after that has bit 11 clear again.
- R9: Characters are received only while `uart_en_i` and `rx_en_i` are both high. Dropping either one returns the receiver to idle on the next clock, with `busy_o` low.
- R10: `busy_o` is high from start-bit detection until the frame ends. After a low stop bit it stays high until the line returns high.
- R11: After reset, `push_o`, `overrun_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | Oversampling pulse, 16 per bit period |
| uart_en_i | input | 1 | Global enable |
| rx_en_i | input | 1 | Receive enable |
| wlen_i | input | 2 | Character length code |
| par_en_i | input | 1 | Parity bit present and checked |
| par_even_i | input | 1 | Even parity select (1 even, 0 odd) |
| par_stick_i | input | 1 | Fixed-value parity select |
| fifo_full_i | input | 1 | Receive FIFO cannot accept a word |
| push_o | output | 1 | Write strobe to the FIFO |
| push_data_o | output | 12 | Tagged character word |
| overrun_o | output | 1 | Pulse when a character is dropped |
| busy_o | output | 1 | Frame reception in progress |

## Verification
The bench concentrates on the cases where a receiver most easily goes wrong.

- A short low glitch must be rejected. A design that trusts the falling edge alone would write a spurious 0xFF-style word.
- A held-low line must produce exactly one break word. A design that goes straight back to hunting for a start bit would write a stream of zero characters with framing errors.
- Overrun must go to the word after the dropped character, and only that one. A design that does this wrong either tags nothing or leaves bit 11 stuck on.
- Stick parity must use the polarity opposite to the even-select bit. Short word lengths must not leak stale upper bits into the data field.
- Dropping an enable mid-frame must idle the receiver at once, without leaving a half-built character to appear later.

// File: rtl/rxt_pkg.sv
package rxt_pkg;
  localparam int DATA_W  = 8;
  localparam int ENTRY_W = DATA_W + 4;
  localparam int FE_BIT  = DATA_W;
  localparam int PE_BIT  = DATA_W + 1;
  localparam int BK_BIT  = DATA_W + 2;
  localparam int OV_BIT  = DATA_W + 3;
  localparam int IDX_W   = $clog2(DATA_W);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAIT_HI
  } rx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       even;
    logic       stick;
  } line_cfg_t;

  function automatic logic [IDX_W-1:0] last_idx(input logic [1:0] wlen);
    return IDX_W'(DATA_W - 4) + IDX_W'(wlen);
  endfunction

  function automatic logic exp_parity(input logic [DATA_W-1:0] d,
                                      input logic even, input logic stick);
    if (stick) return ~even;
    return even ? ^d : ~^d;
  endfunction
endpackage

// File: rtl/rxt_sync.sv
module rxt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= 1'b1;
        else         q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '1;
        else         q <= {q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/rxt_bit_timer.sv
module rxt_bit_timer #(
  parameter int OSR = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clear_i,
  input  logic half_i,
  output logic sample_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] FULL_PT = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] HALF_PT = CNT_W'(OSR / 2 - 1);

  logic [CNT_W-1:0] cnt;
  logic             hit;

  assign hit      = cnt == (half_i ? HALF_PT : FULL_PT);
  assign sample_o = tick_i & ~clear_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)            cnt <= '0;
    else if (clear_i)       cnt <= '0;
    else if (tick_i && hit) cnt <= '0;
    else if (tick_i)        cnt <= cnt + 1'b1;
endmodule

// File: rtl/rxt_frame_fsm.sv
module rxt_frame_fsm
  import rxt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              rx_i,
  input  logic              sample_i,
  input  line_cfg_t         cfg_i,
  output rx_state_e         state_o,
  output logic              done_o,
  output logic [DATA_W-1:0] char_o,
  output logic              fe_o,
  output logic              pe_o,
  output logic              brk_o
);
  rx_state_e         state;
  line_cfg_t         cfg_q;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;
  logic              par_q;
  logic              all_low;

  assign state_o = state;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= S_IDLE;
      cfg_q   <= '0;
      idx     <= '0;
      shreg   <= '0;
      par_q   <= 1'b0;
      all_low <= 1'b0;
      done_o  <= 1'b0;
      char_o  <= '0;
      fe_o    <= 1'b0;
      pe_o    <= 1'b0;
      brk_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!en_i) begin
        state <= S_IDLE;
      end else begin
        unique case (state)
          S_IDLE: if (!rx_i) state <= S_START;
          S_START: if (sample_i) begin
            if (rx_i) state <= S_IDLE;  // glitch
            else begin
              state   <= S_DATA;
              cfg_q   <= cfg_i;
              idx     <= '0;
              shreg   <= '0;
              par_q   <= 1'b0;
              all_low <= 1'b1;
            end
          end
          S_DATA: if (sample_i) begin
            shreg[idx] <= rx_i;
            if (rx_i) all_low <= 1'b0;
            if (idx == last_idx(cfg_q.wlen))
              state <= cfg_q.par_en ? S_PAR : S_STOP;
            else
              idx <= idx + 1'b1;
          end
          S_PAR: if (sample_i) begin
            par_q <= rx_i;
            if (rx_i) all_low <= 1'b0;
            state <= S_STOP;
          end
          S_STOP: if (sample_i) begin
            done_o <= 1'b1;
            char_o <= shreg;
            fe_o   <= ~rx_i;
            brk_o  <= ~rx_i & all_low;
            pe_o   <= cfg_q.par_en & ~(~rx_i & all_low) &
                      (par_q != exp_parity(shreg, cfg_q.even, cfg_q.stick));
            state  <= rx_i ? S_IDLE : S_WAIT_HI;
          end
          S_WAIT_HI: if (rx_i) state <= S_IDLE;
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxt_tagger.sv
module rxt_tagger
  import rxt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               done_i,
  input  logic [DATA_W-1:0]  char_i,
  input  logic               fe_i,
  input  logic               pe_i,
  input  logic               brk_i,
  input  logic               full_i,
  output logic               push_o,
  output logic [ENTRY_W-1:0] entry_o,
  output logic               overrun_o
);
  logic ovr_pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      push_o    <= 1'b0;
      entry_o   <= '0;
      overrun_o <= 1'b0;
      ovr_pend  <= 1'b0;
    end else begin
      push_o    <= 1'b0;
      overrun_o <= 1'b0;
      if (done_i) begin
        if (full_i) begin
          overrun_o <= 1'b1;
          ovr_pend  <= 1'b1;
        end else begin
          push_o   <= 1'b1;
          entry_o  <= {ovr_pend, brk_i, pe_i, fe_i, char_i};
          ovr_pend <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/rx_char_tagger.sv
module rx_char_tagger
  import rxt_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rxd_i,
  input  logic               tick_i,
  input  logic               uart_en_i,
  input  logic               rx_en_i,
  input  logic [1:0]         wlen_i,
  input  logic               par_en_i,
  input  logic               par_even_i,
  input  logic               par_stick_i,
  input  logic               fifo_full_i,
  output logic               push_o,
  output logic [ENTRY_W-1:0] push_data_o,
  output logic               overrun_o,
  output logic               busy_o
);
  logic              rx_s, en, sample, done, fe, pe, brk;
  logic [DATA_W-1:0] char_d;
  rx_state_e         state;
  line_cfg_t         cfg;

  assign en  = uart_en_i & rx_en_i;
  assign cfg = '{wlen: wlen_i, par_en: par_en_i, even: par_even_i, stick: par_stick_i};

  rxt_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rxd_i), .q_o(rx_s)
  );

  rxt_bit_timer #(.OSR(OSR)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .clear_i (state == S_IDLE || state == S_WAIT_HI || !en),
    .half_i  (state == S_START),
    .sample_o(sample)
  );

  rxt_frame_fsm i_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en), .rx_i(rx_s), .sample_i(sample),
    .cfg_i(cfg), .state_o(state), .done_o(done), .char_o(char_d),
    .fe_o(fe), .pe_o(pe), .brk_o(brk)
  );

  rxt_tagger i_tag (
    .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done), .char_i(char_d),
    .fe_i(fe), .pe_i(pe), .brk_i(brk), .full_i(fifo_full_i),
    .push_o(push_o), .entry_o(push_data_o), .overrun_o(overrun_o)
  );

  assign busy_o = state != S_IDLE;
endmodule

// File: rtl/rx_char_tagger_chk.sv
module rx_char_tagger_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        uart_en_i,
  input logic        rx_en_i,
  input logic        fifo_full_i,
  input logic        push_o,
  input logic [11:0] push_data_o,
  input logic        overrun_o,
  input logic        busy_o
);
  a_r8_push_only_with_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> !$past(fifo_full_i));

  a_r8_push_or_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_o && overrun_o));

  a_r1_single_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> !push_o);

  a_r7_break_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && push_data_o[10]) |-> (push_data_o[7:0] == 8'h00 && push_data_o[8] && !push_data_o[9]));

  a_r9_disable_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(uart_en_i && rx_en_i) |=> !busy_o);
endmodule

bind rx_char_tagger rx_char_tagger_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .uart_en_i(uart_en_i), .rx_en_i(rx_en_i),
  .fifo_full_i(fifo_full_i), .push_o(push_o), .push_data_o(push_data_o),
  .overrun_o(overrun_o), .busy_o(busy_o)
);

// File: tb/test_rx_char_tagger.sv
`timescale 1ns/1ps
module test_rx_char_tagger;
  localparam int TICK_DIV = 4;
  localparam int BIT_CYC  = 16 * TICK_DIV;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic rxd = 1'b1, tick = 1'b0;
  logic uart_en = 1'b1, rx_en = 1'b1;
  logic [1:0] wlen = 2'd3;
  logic par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0, fifo_full = 1'b0;
  logic push, ovr, busy;
  logic [11:0] pdata;

  int n_checks = 0, n_errors = 0, ovr_cnt = 0;
  logic [11:0] got_q[$];

  always #2.5 clk = ~clk;

  rx_char_tagger i_rx_char_tagger (
    .clk_i(clk), .rst_ni(rst_ni), .rxd_i(rxd), .tick_i(tick),
    .uart_en_i(uart_en), .rx_en_i(rx_en), .wlen_i(wlen),
    .par_en_i(par_en), .par_even_i(par_even), .par_stick_i(par_stick),
    .fifo_full_i(fifo_full), .push_o(push), .push_data_o(pdata),
    .overrun_o(ovr), .busy_o(busy)
  );

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      tick = (c == TICK_DIV - 1);
      c = (c == TICK_DIV - 1) ? 0 : c + 1;
    end
  end

  initial forever begin
    @(negedge clk);
    if (push) got_q.push_back(pdata);
    if (ovr) ovr_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_words(input string req, input int n, input logic [11:0] w0);
    chk({req, " word count"}, got_q.size(), n);
    if (n > 0 && got_q.size() > 0) chk({req, " word"}, got_q[0], w0);
    got_q.delete();
  endtask

  task automatic hold(input logic b, input int cyc);
    rxd = b;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int nbits, input logic with_par,
                      input logic pbit, input logic stop);
    hold(1'b0, BIT_CYC);
    for (int i = 0; i < nbits; i++) hold(d[i], BIT_CYC);
    if (with_par) hold(pbit, BIT_CYC);
    hold(stop, BIT_CYC);
    hold(1'b1, 2 * BIT_CYC);
  endtask

  task automatic cfg(input logic [1:0] wl, input logic pe, input logic ev, input logic st);
    wlen = wl; par_en = pe; par_even = ev; par_stick = st;
  endtask

  task automatic t_reset;
    chk("R11 push", push, 0);
    chk("R11 overrun", ovr, 0);
    chk("R11 busy", busy, 0);
  endtask

  task automatic t_basic;
    cfg(2'd3, 0, 0, 0);
    send(8'hA5, 8, 0, 0, 1);
    expect_words("R1 8N1 A5", 1, 12'h0A5);
    send(8'h3C, 8, 0, 0, 1);
    expect_words("R1 8N1 3C", 1, 12'h03C);
  endtask

  task automatic t_lengths;
    cfg(2'd0, 0, 0, 0); send(8'hF3, 5, 0, 0, 1); expect_words("R2 len5", 1, 12'h013);
    cfg(2'd1, 0, 0, 0); send(8'hEA, 6, 0, 0, 1); expect_words("R2 len6", 1, 12'h02A);
    cfg(2'd2, 0, 0, 0); send(8'hD5, 7, 0, 0, 1); expect_words("R2 len7", 1, 12'h055);
  endtask

  task automatic t_parity;
    cfg(2'd3, 1, 1, 0);
    send(8'h07, 8, 1, 1'b1, 1); expect_words("R3 even ok", 1, 12'h007);
    send(8'h07, 8, 1, 1'b0, 1); expect_words("R3 even bad", 1, 12'h207);
    cfg(2'd3, 1, 0, 0);
    send(8'h07, 8, 1, 1'b0, 1); expect_words("R3 odd ok", 1, 12'h007);
    send(8'h03, 8, 1, 1'b0, 1); expect_words("R3 odd bad", 1, 12'h203);
  endtask

  task automatic t_stick;
    cfg(2'd3, 1, 1, 1);
    send(8'h01, 8, 1, 1'b0, 1); expect_words("R4 stick0 ok", 1, 12'h001);
    send(8'h01, 8, 1, 1'b1, 1); expect_words("R4 stick0 bad", 1, 12'h201);
    cfg(2'd3, 1, 0, 1);
    send(8'h00, 8, 1, 1'b1, 1); expect_words("R4 stick1 ok", 1, 12'h000);
    send(8'h00, 8, 1, 1'b0, 1); expect_words("R4 stick1 bad", 1, 12'h200);
    cfg(2'd3, 0, 1, 1);
    send(8'h81, 8, 0, 0, 1); expect_words("R4 no parity", 1, 12'h081);
  endtask

  task automatic t_glitch;
    cfg(2'd3, 0, 0, 0);
    hold(1'b0, 3 * TICK_DIV);
    hold(1'b1, 2 * BIT_CYC);
    expect_words("R5 glitch", 0, 12'h000);
    chk("R5 busy after glitch", busy, 0);
  endtask

  task automatic t_framing;
    cfg(2'd3, 0, 0, 0);
    send(8'h3C, 8, 0, 0, 0);
    expect_words("R6 framing", 1, 12'h13C);
    send(8'h5A, 8, 0, 0, 1);
    expect_words("R6 resume", 1, 12'h05A);
  endtask

  task automatic t_break;
    cfg(2'd3, 1, 1, 0);
    hold(1'b0, 14 * BIT_CYC);
    chk("R10 busy during break", busy, 1);
    expect_words("R7 break", 1, 12'h500);
    hold(1'b1, 2 * BIT_CYC);
    chk("R10 idle after break", busy, 0);
    expect_words("R7 no extra", 0, 12'h000);
    cfg(2'd3, 0, 0, 0);
    send(8'h96, 8, 0, 0, 1);
    expect_words("R7 after break", 1, 12'h096);
  endtask

  task automatic t_overrun;
    int base;
    cfg(2'd3, 0, 0, 0);
    base = ovr_cnt;
    fifo_full = 1'b1;
    send(8'h11, 8, 0, 0, 1);
    fifo_full = 1'b0;
    expect_words("R8 dropped", 0, 12'h000);
    chk("R8 overrun pulse", ovr_cnt - base, 1);
    send(8'h22, 8, 0, 0, 1); expect_words("R8 tagged", 1, 12'h822);
    send(8'h33, 8, 0, 0, 1); expect_words("R8 cleared", 1, 12'h033);
  endtask

  task automatic t_enables;
    cfg(2'd3, 0, 0, 0);
    rx_en = 1'b0; send(8'h55, 8, 0, 0, 1); rx_en = 1'b1;
    expect_words("R9 rx disabled", 0, 12'h000);
    uart_en = 1'b0; send(8'h55, 8, 0, 0, 1); uart_en = 1'b1;
    expect_words("R9 uart disabled", 0, 12'h000);
    hold(1'b0, BIT_CYC);
    hold(1'b1, BIT_CYC / 2);
    chk("R10 busy mid frame", busy, 1);
    rx_en = 1'b0;
    @(negedge clk);
    chk("R9 abort idles", busy, 0);
    hold(1'b1, 10 * BIT_CYC);
    rx_en = 1'b1;
    expect_words("R9 abort no word", 0, 12'h000);
    send(8'hC3, 8, 0, 0, 1);
    expect_words("R9 reenabled", 1, 12'hC3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_lengths();
    t_parity();
    t_stick();
    t_glitch();
    t_framing();
    t_break();
    t_overrun();
    t_enables();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule